// File: doc/BRIEF.md
# Overcurrent and Short-Circuit Protection Timer

This block is the digital protection core for the current-sense path of a battery pack controller. Every clock it compares a signed current-sense sample, given in millivolts, against four fault limits: discharge overcurrent, a first and a second short-circuit-in-discharge level, and short circuit in charge. A configuration code sets each limit. A single range bit halves all four limits, for use with a larger sense resistor.

Each fault class runs its own qualification timer. The timer counts ticks of a 32.768 kHz time base, which arrive as one-clock enable pulses on `tick_i`. A fault latches only when its condition has held without a break for the programmed number of ticks. Latched faults raise requests to open the discharge FET or the charge FET. The flags stay set until the host pulses the clear strobe.

Each channel is a three-state machine. `ST_IDLE` is the waiting state. `ST_TIMING` counts ticks while the condition holds. `ST_TRIPPED` holds the latched fault. The transitions are:
- start: `ST_IDLE` to `ST_TIMING`, on the first tick that sees the condition.
- instant: `ST_IDLE` to `ST_TRIPPED`, on that first tick when the delay is zero.
- abort: `ST_TIMING` to `ST_IDLE`, in any clock where the condition is gone.
- expire: `ST_TIMING` to `ST_TRIPPED`, on the tick that completes the delay.
- clear: any state to `ST_IDLE`, on the clear strobe.

Top module: `ocsc_guard`

## Requirements
- R1: While `rst_n` is low and after it is released, `fault_o`, `dsg_off_o` and `chg_off_o` are all 0 until a fault qualifies.
- R2: The discharge overcurrent condition (`fault_o` bit 0) holds when `sense_i >= 50 + 10*code` mV, or `>= 25 + 5*code` mV when `range_half_i` is 1. The code is `ocd_thr_i`, 0 to 15.
- R3: The two short-circuit-in-discharge conditions hold when `sense_i >= 100 + 50*code` mV, or half that when `range_half_i` is 1. The first level is `fault_o` bit 1 with code `sd1_thr_i`. The second level is bit 2 with code `sd2_thr_i`. Codes above 7 act as 7.
- R4: The charge short-circuit condition (`fault_o` bit 3) holds when `sense_i <= -(100 + 50*code)` mV, with codes above 4 acting as 4. When `range_half_i` is 1 it holds when `sense_i <= -(50 + 25*code)` mV, with codes above 7 acting as 7.
- R5: A discharge overcurrent fault latches on the tick that is `33 + 64*ocd_dly_i` ticks after the first tick that saw its condition. That first tick counts as tick 0. The delay-doubling bit does not apply to this channel.
- R6: The short-circuit delays in ticks are `2*sd1_dly_i` for the first discharge level and `sd2_dly_i` for the second. Both are doubled when `delay_dbl_i` is 1. The charge short-circuit delay is `2*scc_dly_i` and ignores `delay_dbl_i`.
- R7: Flags change to 1 only on a clock in which `tick_i` is high. A short-circuit channel whose delay is zero latches on the first tick that sees its condition.
- R8: If a channel's condition is absent in any clock before its delay ends, the count is dropped. The next qualification needs the full delay again.
- R9: A set flag stays set while its condition is gone, until `clear_i` is high for a clock. After that clock all flags are 0 and every count in progress is dropped. A condition still present is re-qualified through its full delay, starting at the next tick.
- R10: `dsg_off_o` is 1 exactly when any of `fault_o` bits 0, 1 and 2 is set. `chg_off_o` is 1 exactly when `fault_o` bit 3 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-clock pulse at the 32.768 kHz time base rate |
| sense_i | input | 16 | Signed current-sense sample in mV; positive means discharge |
| range_half_i | input | 1 | Halves all four thresholds |
| delay_dbl_i | input | 1 | Doubles both short-circuit-in-discharge delays |
| ocd_thr_i | input | 4 | Discharge overcurrent threshold code |
| ocd_dly_i | input | 4 | Discharge overcurrent delay code |
| sd1_thr_i | input | 4 | First short-circuit-in-discharge threshold code |
| sd1_dly_i | input | 4 | First short-circuit-in-discharge delay code |
| sd2_thr_i | input | 4 | Second short-circuit-in-discharge threshold code |
| sd2_dly_i | input | 4 | Second short-circuit-in-discharge delay code |
| scc_thr_i | input | 4 | Charge short-circuit threshold code |
| scc_dly_i | input | 4 | Charge short-circuit delay code |
| clear_i | input | 1 | Host strobe that clears all latched flags |
| fault_o | output | 4 | Latched flags: bit 0 overcurrent, bit 1 and bit 2 discharge short levels, bit 3 charge short |
| dsg_off_o | output | 1 | Request to turn the discharge FET off |
| chg_off_o | output | 1 | Request to turn the charge FET off |

## Verification
Each threshold is tried with a sample 1 mV below the limit and a sample exactly on it. This separates `>=` from `>`, and it catches a wrong step or base in either range. The half range and code clamping are tried for the short channels. Delays are measured by counting ticks from the first qualifying tick. The flag must still be 0 one tick before the programmed count and 1 on it, which catches off-by-one counting and doubling applied to the wrong channel. A held condition with a one-clock dropout, a flag that outlives its condition, and a clear issued while the condition persists tell restart, latching and re-qualification apart.

// File: rtl/ocsc_pkg.sv
package ocsc_pkg;

    // Channel count and flag bit positions
    localparam int NUM_CH = 4;
    localparam int CH_OCD = 0;   // discharge overcurrent
    localparam int CH_SD1 = 1;   // short in discharge, first level
    localparam int CH_SD2 = 2;   // short in discharge, second level
    localparam int CH_SCC = 3;   // short in charge

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_TIMING  = 2'd1,
        ST_TRIPPED = 2'd2
    } chan_state_t;

endpackage

// File: rtl/ocsc_limits.sv
module ocsc_limits
    import ocsc_pkg::*;
#(
    parameter int SENSE_W      = 16,
    parameter int CODE_W       = 4,
    parameter int OCD_BASE_MV  = 50,
    parameter int OCD_STEP_MV  = 10,
    parameter int SCD_BASE_MV  = 100,
    parameter int SCD_STEP_MV  = 50,
    parameter int SCD_TOP_CODE = 7,
    parameter int SCC_BASE_MV  = 100,
    parameter int SCC_STEP_MV  = 50,
    parameter int SCC_TOP_FULL = 4,
    parameter int SCC_TOP_HALF = 7
) (
    input  logic signed [SENSE_W-1:0] sense_i,
    input  logic                      range_half_i,
    input  logic [CODE_W-1:0]         ocd_code_i,
    input  logic [CODE_W-1:0]         sd1_code_i,
    input  logic [CODE_W-1:0]         sd2_code_i,
    input  logic [CODE_W-1:0]         scc_code_i,
    output logic [NUM_CH-1:0]         over_o
);

    localparam int OCD_TOP_CODE = (1 << CODE_W) - 1;

    // Threshold magnitude in mV: clamp code, scale, optionally halve
    function automatic logic [SENSE_W-1:0] level_mv(
        input logic [CODE_W-1:0] code,
        input int unsigned       top,
        input int unsigned       base,
        input int unsigned       step,
        input logic              half
    );
        int unsigned c;
        int unsigned mv;
        c  = (32'(code) > top) ? top : 32'(code);
        mv = base + step * c;
        if (half) begin
            mv = mv >> 1;
        end
        return mv[SENSE_W-1:0];
    endfunction

    logic [NUM_CH-1:0][SENSE_W-1:0] lvl;

    always_comb begin
        lvl[CH_OCD] = level_mv(ocd_code_i, OCD_TOP_CODE, OCD_BASE_MV, OCD_STEP_MV, range_half_i);
        lvl[CH_SD1] = level_mv(sd1_code_i, SCD_TOP_CODE, SCD_BASE_MV, SCD_STEP_MV, range_half_i);
        lvl[CH_SD2] = level_mv(sd2_code_i, SCD_TOP_CODE, SCD_BASE_MV, SCD_STEP_MV, range_half_i);
        lvl[CH_SCC] = level_mv(scc_code_i, range_half_i ? SCC_TOP_HALF : SCC_TOP_FULL,
                               SCC_BASE_MV, SCC_STEP_MV, range_half_i);
    end

    // Discharge channels compare upward, the charge channel downward
    for (genvar g = 0; g < NUM_CH; g++) begin : g_cmp
        if (g == CH_SCC) begin : g_neg
            assign over_o[g] = (sense_i <= -$signed(lvl[g]));
        end else begin : g_pos
            assign over_o[g] = (sense_i >= $signed(lvl[g]));
        end
    end

endmodule

// File: rtl/ocsc_timing.sv
module ocsc_timing
    import ocsc_pkg::*;
#(
    parameter int CODE_W      = 4,
    parameter int CNT_W       = 10,
    parameter int OCD_BASE_TK = 33,
    parameter int OCD_STEP_TK = 64,
    parameter int SD1_STEP_TK = 2,
    parameter int SD2_STEP_TK = 1,
    parameter int SCC_STEP_TK = 2
) (
    input  logic                         delay_dbl_i,
    input  logic [CODE_W-1:0]            ocd_code_i,
    input  logic [CODE_W-1:0]            sd1_code_i,
    input  logic [CODE_W-1:0]            sd2_code_i,
    input  logic [CODE_W-1:0]            scc_code_i,
    output logic [NUM_CH-1:0][CNT_W-1:0] target_o
);

    // Delay code to tick count, optionally doubled
    function automatic logic [CNT_W-1:0] to_ticks(
        input logic [CODE_W-1:0] code,
        input int unsigned       base,
        input int unsigned       step,
        input logic              dbl
    );
        int unsigned t;
        t = base + step * 32'(code);
        if (dbl) begin
            t = t << 1;
        end
        return t[CNT_W-1:0];
    endfunction

    always_comb begin
        target_o[CH_OCD] = to_ticks(ocd_code_i, OCD_BASE_TK, OCD_STEP_TK, 1'b0);
        target_o[CH_SD1] = to_ticks(sd1_code_i, 0, SD1_STEP_TK, delay_dbl_i);
        target_o[CH_SD2] = to_ticks(sd2_code_i, 0, SD2_STEP_TK, delay_dbl_i);
        target_o[CH_SCC] = to_ticks(scc_code_i, 0, SCC_STEP_TK, 1'b0);
    end

endmodule

// File: rtl/ocsc_chan.sv
module ocsc_chan
    import ocsc_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             over_i,
    input  logic             clear_i,
    input  logic [CNT_W-1:0] target_i,
    output logic             tripped_o
);

    chan_state_t      st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt_q} + (CNT_W+1)'(1);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Next state: clear dominates, then start / instant / abort / expire
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (clear_i) begin
            st_d  = ST_IDLE;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (tick_i && over_i) begin
                        if (target_i == '0) begin
                            st_d = ST_TRIPPED;
                        end else begin
                            st_d  = ST_TIMING;
                            cnt_d = '0;
                        end
                    end
                end
                ST_TIMING: begin
                    if (!over_i) begin
                        st_d  = ST_IDLE;
                        cnt_d = '0;
                    end else if (tick_i) begin
                        if (cnt_inc >= {1'b0, target_i}) begin
                            st_d = ST_TRIPPED;
                        end else begin
                            cnt_d = cnt_inc[CNT_W-1:0];
                        end
                    end
                end
                ST_TRIPPED: begin
                    st_d = ST_TRIPPED;
                end
                default: begin
                    st_d  = ST_IDLE;
                    cnt_d = '0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        tripped_o = (st_q == ST_TRIPPED);
    end

endmodule

// File: rtl/ocsc_guard.sv
module ocsc_guard
    import ocsc_pkg::*;
#(
    parameter int SENSE_W     = 16,
    parameter int CODE_W      = 4,
    parameter int OCD_BASE_MV = 50,
    parameter int OCD_STEP_MV = 10,
    parameter int SCD_BASE_MV = 100,
    parameter int SCD_STEP_MV = 50,
    parameter int SCC_BASE_MV = 100,
    parameter int SCC_STEP_MV = 50,
    parameter int OCD_BASE_TK = 33,
    parameter int OCD_STEP_TK = 64,
    parameter int SD1_STEP_TK = 2,
    parameter int SD2_STEP_TK = 1,
    parameter int SCC_STEP_TK = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tick_i,
    input  logic signed [SENSE_W-1:0] sense_i,
    input  logic                      range_half_i,
    input  logic                      delay_dbl_i,
    input  logic [CODE_W-1:0]         ocd_thr_i,
    input  logic [CODE_W-1:0]         ocd_dly_i,
    input  logic [CODE_W-1:0]         sd1_thr_i,
    input  logic [CODE_W-1:0]         sd1_dly_i,
    input  logic [CODE_W-1:0]         sd2_thr_i,
    input  logic [CODE_W-1:0]         sd2_dly_i,
    input  logic [CODE_W-1:0]         scc_thr_i,
    input  logic [CODE_W-1:0]         scc_dly_i,
    input  logic                      clear_i,
    output logic [3:0]                fault_o,
    output logic                      dsg_off_o,
    output logic                      chg_off_o
);

    localparam int TOP_CODE = (1 << CODE_W) - 1;
    localparam int MAX_OCD  = OCD_BASE_TK + OCD_STEP_TK * TOP_CODE;
    localparam int MAX_SD1  = 2 * SD1_STEP_TK * TOP_CODE;
    localparam int MAX_SD2  = 2 * SD2_STEP_TK * TOP_CODE;
    localparam int MAX_SCC  = SCC_STEP_TK * TOP_CODE;
    localparam int MAX_AB   = (MAX_OCD > MAX_SD1) ? MAX_OCD : MAX_SD1;
    localparam int MAX_CD   = (MAX_SD2 > MAX_SCC) ? MAX_SD2 : MAX_SCC;
    localparam int MAX_TK   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CNT_W    = $clog2(MAX_TK + 1);

    logic [NUM_CH-1:0]            over_lim;
    logic [NUM_CH-1:0][CNT_W-1:0] target;
    logic [NUM_CH-1:0]            trip;

    ocsc_limits #(
        .SENSE_W     (SENSE_W),
        .CODE_W      (CODE_W),
        .OCD_BASE_MV (OCD_BASE_MV),
        .OCD_STEP_MV (OCD_STEP_MV),
        .SCD_BASE_MV (SCD_BASE_MV),
        .SCD_STEP_MV (SCD_STEP_MV),
        .SCD_TOP_CODE(7),
        .SCC_BASE_MV (SCC_BASE_MV),
        .SCC_STEP_MV (SCC_STEP_MV),
        .SCC_TOP_FULL(4),
        .SCC_TOP_HALF(7)
    ) u_limits (
        .sense_i     (sense_i),
        .range_half_i(range_half_i),
        .ocd_code_i  (ocd_thr_i),
        .sd1_code_i  (sd1_thr_i),
        .sd2_code_i  (sd2_thr_i),
        .scc_code_i  (scc_thr_i),
        .over_o      (over_lim)
    );

    ocsc_timing #(
        .CODE_W     (CODE_W),
        .CNT_W      (CNT_W),
        .OCD_BASE_TK(OCD_BASE_TK),
        .OCD_STEP_TK(OCD_STEP_TK),
        .SD1_STEP_TK(SD1_STEP_TK),
        .SD2_STEP_TK(SD2_STEP_TK),
        .SCC_STEP_TK(SCC_STEP_TK)
    ) u_timing (
        .delay_dbl_i(delay_dbl_i),
        .ocd_code_i (ocd_dly_i),
        .sd1_code_i (sd1_dly_i),
        .sd2_code_i (sd2_dly_i),
        .scc_code_i (scc_dly_i),
        .target_o   (target)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        ocsc_chan #(
            .CNT_W(CNT_W)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_i   (tick_i),
            .over_i   (over_lim[g]),
            .clear_i  (clear_i),
            .target_i (target[g]),
            .tripped_o(trip[g])
        );
    end

    // Outputs: flags and FET-off requests
    always_comb begin
        fault_o   = trip;
        dsg_off_o = trip[CH_OCD] | trip[CH_SD1] | trip[CH_SD2];
        chg_off_o = trip[CH_SCC];
    end

endmodule

// File: rtl/ocsc_guard_chk.sv
module ocsc_guard_chk
    import ocsc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              clear,
    input logic [NUM_CH-1:0] over,
    input logic [NUM_CH-1:0] fault,
    input logic              dsg_off,
    input logic              chg_off
);

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        // R9
        flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (fault[k] && !clear) |=> fault[k]);

        // R7
        tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(fault[k]) |-> $past(tick));

        // R8
        over_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(fault[k]) |-> $past(over[k]));
    end

    // R9
    clear_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (fault == '0));

    // R10
    dsg_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dsg_off) |-> ($past(tick) && ($past(over[CH_OCD]) || $past(over[CH_SD1]) || $past(over[CH_SD2]))));

    // R10
    chg_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chg_off) |-> ($past(tick) && $past(over[CH_SCC])));

endmodule

bind ocsc_guard ocsc_guard_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick_i),
    .clear  (clear_i),
    .over   (over_lim),
    .fault  (fault_o),
    .dsg_off(dsg_off_o),
    .chg_off(chg_off_o)
);

// File: tb/ocsc_guard_tb_top.sv
module ocsc_guard_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int WDOG_LIMIT = 100000;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               tick = 1'b0;
    logic signed [15:0] sense = '0;
    logic               range_half = 1'b0;
    logic               delay_dbl = 1'b0;
    logic [3:0]         ocd_thr = '0, ocd_dly = '0;
    logic [3:0]         sd1_thr = '0, sd1_dly = '0;
    logic [3:0]         sd2_thr = '0, sd2_dly = '0;
    logic [3:0]         scc_thr = '0, scc_dly = '0;
    logic               clear = 1'b0;
    logic [3:0]         fault;
    logic               dsg_off, chg_off;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit done = 1'b0;

    ocsc_guard dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .sense_i     (sense),
        .range_half_i(range_half),
        .delay_dbl_i (delay_dbl),
        .ocd_thr_i   (ocd_thr),
        .ocd_dly_i   (ocd_dly),
        .sd1_thr_i   (sd1_thr),
        .sd1_dly_i   (sd1_dly),
        .sd2_thr_i   (sd2_thr),
        .sd2_dly_i   (sd2_dly),
        .scc_thr_i   (scc_thr),
        .scc_dly_i   (scc_dly),
        .clear_i     (clear),
        .fault_o     (fault),
        .dsg_off_o   (dsg_off),
        .chg_off_o   (chg_off)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Time-base pulse: one clock high every TICK_DIV clocks
    initial begin
        forever begin
            repeat (TICK_DIV-1) @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WDOG_LIMIT && !done) begin
            total = total + 1;
            bad   = bad + 1;
            $display("FAIL watchdog (all requirements) actual=%0d cycles expected<=%0d", cycles, WDOG_LIMIT);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic expect_val(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Wait for n tick edges, then sample point at the following negedge
    task automatic count_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            while (!tick) @(posedge clk);
        end
        @(negedge clk);
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
    endtask

    // Start from a quiet state with all limits far from the stimulus
    task automatic quiet_setup();
        @(negedge clk);
        sense      = '0;
        range_half = 1'b0;
        delay_dbl  = 1'b0;
        ocd_thr = 4'd15; ocd_dly = 4'd0;
        sd1_thr = 4'd7;  sd1_dly = 4'd0;
        sd2_thr = 4'd7;  sd2_dly = 4'd0;
        scc_thr = 4'd4;  scc_dly = 4'd0;
        pulse_clear();
    endtask

    // Flag must be 0 after d ticks and 1 on the next
    task automatic qualify(input int idx, input int d, input string req);
        if (d > 0) begin
            count_ticks(d);
            expect_val(req, $sformatf("flag%0d one tick early (delay %0d)", idx, d), 32'(fault[idx]), 0);
        end
        count_ticks(1);
        expect_val(req, $sformatf("flag%0d at delay %0d", idx, d), 32'(fault[idx]), 1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        expect_val("R1", "flags in reset", 32'(fault), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        expect_val("R1", "flags after reset", 32'(fault), 0);
        expect_val("R1", "dsg request after reset", 32'(dsg_off), 0);
        expect_val("R1", "chg request after reset", 32'(chg_off), 0);
    endtask

    task automatic t_ocd_full();
        quiet_setup();
        ocd_thr = 4'd3;  // 80 mV
        ocd_dly = 4'd0;  // 33 ticks
        sense   = 16'sd79;
        count_ticks(40);
        expect_val("R2", "overcurrent just below 80 mV", 32'(fault[0]), 0);
        sense = 16'sd80;
        qualify(0, 33, "R5");
        expect_val("R10", "dsg request from overcurrent", 32'(dsg_off), 1);
        expect_val("R10", "chg request from overcurrent", 32'(chg_off), 0);
    endtask

    task automatic t_ocd_half();
        quiet_setup();
        range_half = 1'b1;
        ocd_thr    = 4'd3;  // 40 mV
        ocd_dly    = 4'd1;  // 97 ticks
        delay_dbl  = 1'b1;  // must not affect overcurrent
        sense      = 16'sd39;
        count_ticks(100);
        expect_val("R2", "half-range overcurrent just below 40 mV", 32'(fault[0]), 0);
        sense = 16'sd40;
        qualify(0, 97, "R5");
    endtask

    task automatic t_sd1();
        quiet_setup();
        sd1_thr = 4'd2;  // 200 mV
        sd1_dly = 4'd3;  // 6 ticks
        sense   = 16'sd199;
        count_ticks(10);
        expect_val("R3", "first short level just below 200 mV", 32'(fault[1]), 0);
        sense = 16'sd200;
        qualify(1, 6, "R6");
        sense = '0;
        pulse_clear();
        delay_dbl = 1'b1;  // 12 ticks
        sense     = 16'sd200;
        qualify(1, 12, "R6");
    endtask

    task automatic t_sd2();
        quiet_setup();
        sd2_thr = 4'd9;  // clamps to 450 mV
        sd2_dly = 4'd5;  // 5 ticks
        sense   = 16'sd449;
        count_ticks(8);
        expect_val("R3", "second short level code clamp, 449 mV", 32'(fault[2]), 0);
        sense = 16'sd450;
        qualify(2, 5, "R6");
        sense = '0;
        pulse_clear();
        range_half = 1'b1;  // 225 mV
        delay_dbl  = 1'b1;  // 10 ticks
        sense      = 16'sd224;
        count_ticks(12);
        expect_val("R3", "second short level half range, 224 mV", 32'(fault[2]), 0);
        sense = 16'sd225;
        qualify(2, 10, "R6");
    endtask

    task automatic t_scc();
        quiet_setup();
        scc_thr   = 4'd6;  // clamps to 4: -300 mV
        scc_dly   = 4'd3;  // 6 ticks
        delay_dbl = 1'b1;  // ignored by charge channel
        sense     = -16'sd299;
        count_ticks(10);
        expect_val("R4", "charge short at -299 mV", 32'(fault[3]), 0);
        expect_val("R10", "chg request idle", 32'(chg_off), 0);
        sense = -16'sd300;
        qualify(3, 6, "R6");
        expect_val("R10", "chg request from charge short", 32'(chg_off), 1);
        expect_val("R10", "dsg request stays off", 32'(dsg_off), 0);
        expect_val("R4", "discharge flags stay off", 32'(fault[2:0]), 0);
        sense = '0;
        pulse_clear();
        range_half = 1'b1;  // code 6: -200 mV
        sense      = -16'sd199;
        count_ticks(10);
        expect_val("R4", "half-range charge short at -199 mV", 32'(fault[3]), 0);
        sense = -16'sd200;
        qualify(3, 6, "R4");
    endtask

    task automatic t_zero();
        quiet_setup();
        sd1_thr = 4'd0;  // 100 mV
        sd1_dly = 4'd0;
        count_ticks(1);  // align just after a tick
        sense = 16'sd100;
        repeat (TICK_DIV-2) @(negedge clk);
        expect_val("R7", "zero delay waits for a tick", 32'(fault[1]), 0);
        count_ticks(1);
        expect_val("R7", "zero delay latches on first tick", 32'(fault[1]), 1);
    endtask

    task automatic t_drop();
        quiet_setup();
        ocd_thr = 4'd0;  // 50 mV
        ocd_dly = 4'd0;  // 33 ticks
        sense   = 16'sd60;
        count_ticks(20);
        expect_val("R8", "no flag midway", 32'(fault[0]), 0);
        sense = '0;
        @(negedge clk);
        sense = 16'sd60;
        qualify(0, 33, "R8");
    endtask

    task automatic t_clear();
        quiet_setup();
        sd2_thr = 4'd0;  // 100 mV
        sd2_dly = 4'd2;  // 2 ticks
        sense   = 16'sd150;
        qualify(2, 2, "R9");
        sense = '0;
        count_ticks(10);
        expect_val("R9", "flag held after condition gone", 32'(fault[2]), 1);
        expect_val("R10", "dsg request held", 32'(dsg_off), 1);
        sense = 16'sd150;
        pulse_clear();
        expect_val("R9", "all flags after clear", 32'(fault), 0);
        expect_val("R10", "dsg request after clear", 32'(dsg_off), 0);
        qualify(2, 2, "R9");
    endtask

    initial begin
        t_reset();
        t_ocd_full();
        t_ocd_half();
        t_sd1();
        t_sd2();
        t_scc();
        t_zero();
        t_drop();
        t_clear();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule